// File: doc/BRIEF.md
# Exception Prioritizer and Vector Selector

This block sits beside the completion stage of a simple in-order core and decides which pending exception to take next. It gathers four kinds of request: non-maskable asynchronous ones (system reset, machine check), synchronous faults reported by instruction slots that carry a program-order age, debug conditions raised as an instruction completes (address breakpoint, trace), and maskable asynchronous ones (system-management pin, external, thermal, decrementer, performance monitor). It ranks them by class and applies the enable conditions that machine-state bits place on each source. It then issues a one-clock take strobe together with the vector offset of the winner.

Asynchronous sources are edge-latched into pending bits. A pending bit stays set until its exception is taken. Synchronous and debug conditions are level inputs. The core holds them until it sees the take strobe and drops them in the following cycle, because the flush removes the instruction. A machine check that arrives while machine check is disabled does not raise an exception: it trips a sticky checkstop flag instead. A combinational recoverable-state flag is also provided. No data stream crosses this block. The take strobe carries no ready signal, because the core cannot refuse an exception, so there is no back-pressure.

Top module: `exc_prio_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `take_o` and `checkstop_o` are 0 and `vec_o` is 0.
- R2: A rising edge on `sreset_i` is latched and taken with vector 0x00100 ahead of every other source. Non-maskable takes may follow a take in the very next cycle.
- R3: When `msr_me_i` is 1 at its rising edge, `mchk_i` is latched and taken with vector 0x00200. It ranks below system reset and above everything else.
- R4: When `msr_me_i` is 0 at a rising edge of `mchk_i`, `checkstop_o` goes to 1 and stays there until `rst_n`. From that edge on, no take is issued.
- R5: Each fault slot has a kind code, with 0 = program (0x00700), 1 = floating-point unavailable (0x00800), 2 = system call (0x00C00) and 3 = no fault. Kind 1 is ignored while `msr_fp_i` is 1. Among the eligible slots, the one with the smallest age is taken. On equal ages, the lowest slot index is taken.
- R6: The synchronous class outranks the maskable class. Within it, faults come first, then the breakpoint (0x01300), then trace (0x00D00). A breakpoint matches when `cmpl_vld_i` is set, `bp_en_i` is 1, `bp_addr_i` equals `cmpl_waddr_i`, and `bp_te_i` equals `msr_ir_i`.
- R7: Trace requests when `cmpl_vld_i` is set and either `msr_se_i` is 1, or `cmpl_branch_i` and `msr_be_i` are both 1. It never requests while `cmpl_isync_i` is 1.
- R8: The decrementer is latched only on a 0-to-1 change of `dec_msb_i` that happens while `msr_ee_i` is 1. It is taken with vector 0x00900.
- R9: Pending maskable requests are taken only while `msr_ee_i` is 1 and are held while it is 0. Their fixed order is system management (0x01400), external (0x00500), thermal (0x01700), decrementer, then performance monitor (0x00F00). Each one except the decrementer latches on a rising edge of its input.
- R10: A request visible in cycle t produces `take_o`=1 for exactly one clock in cycle t+1. The chosen pending bit is cleared and all others are kept. In the cycle where `take_o` is 1, only non-maskable requests can be selected.
- R11: A maskable edge that arrives while `take_o` is 1 is kept pending and is taken later.
- R12: `recov_o` is 1 exactly when `msr_ri_i`, `stq_empty_i` and `next_done_i` are all 1, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sreset_i | input | 1 | System reset request level |
| mchk_i | input | 1 | Machine-check condition level |
| msr_me_i | input | 1 | Machine-check enable |
| flt_vld_i | input | NSLOT | Fault slot valid |
| flt_kind_i | input | 2*NSLOT | Fault kind per slot |
| flt_age_i | input | AGE_W*NSLOT | Program-order age per slot, smaller is older |
| cmpl_vld_i | input | 1 | An instruction is completing |
| cmpl_branch_i | input | 1 | Completing instruction is a branch |
| cmpl_isync_i | input | 1 | Completing instruction is an isync |
| cmpl_waddr_i | input | IA_W | Word address of the completing instruction |
| bp_addr_i | input | IA_W | Breakpoint word address |
| bp_te_i | input | 1 | Breakpoint translation match bit |
| bp_en_i | input | 1 | Breakpoint enable |
| ext_i | input | 1 | External interrupt |
| dec_msb_i | input | 1 | Decrementer most significant bit |
| smi_i | input | 1 | System-management pin |
| thrm_i | input | 1 | Thermal alarm |
| perf_i | input | 1 | Performance monitor alert |
| msr_ee_i | input | 1 | External enable |
| msr_se_i | input | 1 | Single-step enable |
| msr_be_i | input | 1 | Branch trace enable |
| msr_fp_i | input | 1 | Floating point available |
| msr_ir_i | input | 1 | Instruction translation on |
| msr_ri_i | input | 1 | Recoverable-interrupt bit |
| stq_empty_i | input | 1 | Completed-store queue drained |
| next_done_i | input | 1 | Next instruction in order has completed |
| take_o | output | 1 | One-clock take strobe |
| vec_o | output | 20 | Vector offset, 0 when no take |
| checkstop_o | output | 1 | Sticky checkstop |
| recov_o | output | 1 | Recoverable state |

## Verification
The assertions rely on the core dropping its fault, breakpoint and trace levels in the cycle after a take, so that none of them is taken twice. They also rely on asynchronous inputs being low while reset is applied, because an input that is already high when reset is released counts as an edge. The stimulus holds each synchronous condition for a single cycle with idle cycles around it. It raises asynchronous levels only after reset and lowers them before it raises them again. A behavioural model in the bench predicts every output on every clock.

// File: rtl/exc_prio_pkg.sv
package exc_prio_pkg;

  localparam int VEC_W = 20;
  typedef logic [VEC_W-1:0] vec_t;

  // Asynchronous source indices; index order is the selection priority.
  localparam int SRC_N  = 7;
  localparam int NMI_N  = 2;
  localparam int S_SRST = 0;
  localparam int S_MCHK = 1;
  localparam int S_SMI  = 2;
  localparam int S_EXT  = 3;
  localparam int S_THRM = 4;
  localparam int S_DEC  = 5;
  localparam int S_PERF = 6;

  localparam vec_t V_SRST  = 20'h00100;
  localparam vec_t V_MCHK  = 20'h00200;
  localparam vec_t V_EXT   = 20'h00500;
  localparam vec_t V_PROG  = 20'h00700;
  localparam vec_t V_FPU   = 20'h00800;
  localparam vec_t V_DEC   = 20'h00900;
  localparam vec_t V_SC    = 20'h00C00;
  localparam vec_t V_TRACE = 20'h00D00;
  localparam vec_t V_PERF  = 20'h00F00;
  localparam vec_t V_IABR  = 20'h01300;
  localparam vec_t V_SMI   = 20'h01400;
  localparam vec_t V_THRM  = 20'h01700;

  typedef enum logic [1:0] {
    FK_PROG = 2'd0,
    FK_FPU  = 2'd1,
    FK_SC   = 2'd2,
    FK_NONE = 2'd3
  } fkind_e;

  localparam int KIND_W = $bits(fkind_e);

  function automatic vec_t src_vec(input int idx);
    case (idx)
      S_SRST:  return V_SRST;
      S_MCHK:  return V_MCHK;
      S_SMI:   return V_SMI;
      S_EXT:   return V_EXT;
      S_THRM:  return V_THRM;
      S_DEC:   return V_DEC;
      default: return V_PERF;
    endcase
  endfunction

  function automatic logic is_maskable(input vec_t v);
    return (v == V_SMI) || (v == V_EXT) || (v == V_THRM) ||
           (v == V_DEC) || (v == V_PERF);
  endfunction

endpackage

// File: rtl/exc_edge_latch.sv
module exc_edge_latch #(
  parameter int N = 7,
  parameter logic [N-1:0] TRIP_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] arm_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o,
  output logic         trip_o
);

  logic [N-1:0] prev_q;
  logic [N-1:0] pend_q;
  logic [N-1:0] rise;

  assign rise   = lvl_i & ~prev_q;
  assign pend_o = pend_q;
  // A refused edge on a masked-in source (disabled machine check).
  assign trip_o = |(rise & ~arm_i & TRIP_MASK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= lvl_i;
      // a fresh edge wins over a clear in the same cycle
      pend_q <= (pend_q & ~clr_i) | (rise & arm_i);
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_chk
    assert_armed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[g]) |-> $past(arm_i[g]));
    assert_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !(lvl_i[g] && !prev_q[g])) |=> !pend_q[g]);
  end

endmodule

// File: rtl/exc_sync_pick.sv
module exc_sync_pick
  import exc_prio_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int AGE_W = 4
) (
  input  logic [NSLOT-1:0]        vld_i,
  input  logic [KIND_W*NSLOT-1:0] kind_i,
  input  logic [AGE_W*NSLOT-1:0]  age_i,
  input  logic                    fp_on_i,
  output logic                    hit_o,
  output vec_t                    vec_o
);

  logic [NSLOT-1:0] elig;
  fkind_e           kind [NSLOT];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign kind[s] = fkind_e'(kind_i[KIND_W*s +: KIND_W]);
    assign elig[s] = vld_i[s] && (kind[s] != FK_NONE) &&
                     !((kind[s] == FK_FPU) && fp_on_i);
  end

  logic [AGE_W-1:0] best_age;
  fkind_e           best_kind;

  always_comb begin
    hit_o     = 1'b0;
    best_age  = '0;
    best_kind = FK_PROG;
    for (int s = 0; s < NSLOT; s++) begin
      // strict compare keeps the lower index on equal ages
      if (elig[s] && (!hit_o || (age_i[AGE_W*s +: AGE_W] < best_age))) begin
        hit_o     = 1'b1;
        best_age  = age_i[AGE_W*s +: AGE_W];
        best_kind = kind[s];
      end
    end
  end

  always_comb begin
    vec_o = '0;
    if (hit_o) begin
      case (best_kind)
        FK_FPU:  vec_o = V_FPU;
        FK_SC:   vec_o = V_SC;
        default: vec_o = V_PROG;
      endcase
    end
  end

  always_comb begin
    if (!(|vld_i)) begin
      assert_idle_R5: assert (!hit_o);
    end
  end

endmodule

// File: rtl/exc_prio_top.sv
module exc_prio_top
  import exc_prio_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int AGE_W = 4,
  parameter int IA_W  = 30
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sreset_i,
  input  logic                    mchk_i,
  input  logic                    msr_me_i,
  input  logic [NSLOT-1:0]        flt_vld_i,
  input  logic [2*NSLOT-1:0]      flt_kind_i,
  input  logic [AGE_W*NSLOT-1:0]  flt_age_i,
  input  logic                    cmpl_vld_i,
  input  logic                    cmpl_branch_i,
  input  logic                    cmpl_isync_i,
  input  logic [IA_W-1:0]         cmpl_waddr_i,
  input  logic [IA_W-1:0]         bp_addr_i,
  input  logic                    bp_te_i,
  input  logic                    bp_en_i,
  input  logic                    ext_i,
  input  logic                    dec_msb_i,
  input  logic                    smi_i,
  input  logic                    thrm_i,
  input  logic                    perf_i,
  input  logic                    msr_ee_i,
  input  logic                    msr_se_i,
  input  logic                    msr_be_i,
  input  logic                    msr_fp_i,
  input  logic                    msr_ir_i,
  input  logic                    msr_ri_i,
  input  logic                    stq_empty_i,
  input  logic                    next_done_i,
  output logic                    take_o,
  output logic [VEC_W-1:0]        vec_o,
  output logic                    checkstop_o,
  output logic                    recov_o
);

  localparam logic [SRC_N-1:0] TRIP_MASK = SRC_N'(1) << S_MCHK;

  logic [SRC_N-1:0] src_lvl, src_arm, src_clr, src_pend;
  logic             mchk_trip;

  always_comb begin
    src_lvl         = '0;
    src_lvl[S_SRST] = sreset_i;
    src_lvl[S_MCHK] = mchk_i;
    src_lvl[S_SMI]  = smi_i;
    src_lvl[S_EXT]  = ext_i;
    src_lvl[S_THRM] = thrm_i;
    src_lvl[S_DEC]  = dec_msb_i;
    src_lvl[S_PERF] = perf_i;
    src_arm         = '1;
    src_arm[S_MCHK] = msr_me_i;
    src_arm[S_DEC]  = msr_ee_i;
  end

  exc_edge_latch #(.N(SRC_N), .TRIP_MASK(TRIP_MASK)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (src_lvl),
    .arm_i  (src_arm),
    .clr_i  (src_clr),
    .pend_o (src_pend),
    .trip_o (mchk_trip)
  );

  logic sync_hit;
  vec_t sync_vec;

  exc_sync_pick #(.NSLOT(NSLOT), .AGE_W(AGE_W)) u_sync (
    .vld_i   (flt_vld_i),
    .kind_i  (flt_kind_i),
    .age_i   (flt_age_i),
    .fp_on_i (msr_fp_i),
    .hit_o   (sync_hit),
    .vec_o   (sync_vec)
  );

  logic bp_hit, trc_hit;
  assign bp_hit  = cmpl_vld_i && bp_en_i && (bp_addr_i == cmpl_waddr_i) &&
                   (bp_te_i == msr_ir_i);
  assign trc_hit = cmpl_vld_i && !cmpl_isync_i &&
                   (msr_se_i || (cmpl_branch_i && msr_be_i));

  logic take_q, stop_q;
  vec_t vec_q;
  logic allow, sel_vld;
  vec_t sel_vec;

  assign allow = !stop_q && !mchk_trip;

  always_comb begin
    sel_vld = 1'b0;
    sel_vec = '0;
    src_clr = '0;
    if (allow) begin
      for (int k = 0; k < NMI_N; k++) begin
        if (!sel_vld && src_pend[k]) begin
          sel_vld    = 1'b1;
          sel_vec    = src_vec(k);
          src_clr[k] = 1'b1;
        end
      end
      if (!sel_vld && !take_q) begin
        if (sync_hit) begin
          sel_vld = 1'b1;
          sel_vec = sync_vec;
        end else if (bp_hit) begin
          sel_vld = 1'b1;
          sel_vec = V_IABR;
        end else if (trc_hit) begin
          sel_vld = 1'b1;
          sel_vec = V_TRACE;
        end else if (msr_ee_i) begin
          for (int k = NMI_N; k < SRC_N; k++) begin
            if (!sel_vld && src_pend[k]) begin
              sel_vld    = 1'b1;
              sel_vec    = src_vec(k);
              src_clr[k] = 1'b1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      vec_q  <= '0;
      stop_q <= 1'b0;
    end else begin
      take_q <= sel_vld;
      vec_q  <= sel_vld ? sel_vec : '0;
      stop_q <= stop_q | mchk_trip;
    end
  end

  assign take_o      = take_q;
  assign vec_o       = vec_q;
  assign checkstop_o = stop_q;
  assign recov_o     = msr_ri_i && stq_empty_i && next_done_i;

  assert_stop_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    checkstop_o |=> checkstop_o);
  assert_stop_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    checkstop_o |-> !take_o);
  assert_take_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> (!take_o || vec_o == V_SRST || vec_o == V_MCHK));
  assert_mask_ee_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && is_maskable(vec_o)) |-> $past(msr_ee_i));
  assert_no_isync_trace_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && vec_o == V_TRACE) |-> !$past(cmpl_isync_i));
  assert_idle_vec_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> (vec_o == '0));

endmodule

// File: tb/exc_prio_top_tb.sv
module exc_prio_top_tb;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n;
  logic        sreset, mchk, me;
  logic [3:0]  f_vld;
  logic [7:0]  f_kind;
  logic [15:0] f_age;
  logic        c_vld, c_br, c_isync;
  logic [29:0] c_wa, bp_a;
  logic        bp_te, bp_en;
  logic        ext, dec, smi, thrm, perf;
  logic        ee, se, be, fp, ir, ri, stq, nd;
  logic        take_o, checkstop_o, recov_o;
  logic [19:0] vec_o;

  exc_prio_top u_dut (
    .clk(clk), .rst_n(rst_n), .sreset_i(sreset), .mchk_i(mchk), .msr_me_i(me),
    .flt_vld_i(f_vld), .flt_kind_i(f_kind), .flt_age_i(f_age),
    .cmpl_vld_i(c_vld), .cmpl_branch_i(c_br), .cmpl_isync_i(c_isync),
    .cmpl_waddr_i(c_wa), .bp_addr_i(bp_a), .bp_te_i(bp_te), .bp_en_i(bp_en),
    .ext_i(ext), .dec_msb_i(dec), .smi_i(smi), .thrm_i(thrm), .perf_i(perf),
    .msr_ee_i(ee), .msr_se_i(se), .msr_be_i(be), .msr_fp_i(fp), .msr_ir_i(ir),
    .msr_ri_i(ri), .stq_empty_i(stq), .next_done_i(nd),
    .take_o(take_o), .vec_o(vec_o), .checkstop_o(checkstop_o), .recov_o(recov_o)
  );

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [19:0] v);
    case (v)
      20'h00100: return "R2";
      20'h00200: return "R3";
      20'h00700, 20'h00800, 20'h00C00: return "R5";
      20'h01300, 20'h00D00: return "R6";
      20'h00900: return "R8";
      20'h00000: return "R10";
      default:   return "R9";
    endcase
  endfunction

  // ---------------- behavioural reference model ----------------
  bit          m_prev [7];
  bit          m_pend [7];
  bit          m_cs, m_take;
  logic [19:0] m_vec;
  bit          lv [7];
  bit          arm [7];
  int          pick;
  logic [19:0] mv;
  bit          trip;
  logic [19:0] ord_vec [5] = '{20'h01400, 20'h00500, 20'h01700, 20'h00900, 20'h00F00};

  function automatic bit slot_ok(input int s);
    logic [1:0] k;
    k = f_kind[2*s +: 2];
    return f_vld[s] && (k != 2'd3) && !(k == 2'd1 && fp);
  endfunction

  function automatic logic [19:0] slot_vec(input int s);
    case (f_kind[2*s +: 2])
      2'd1:    return 20'h00800;
      2'd2:    return 20'h00C00;
      default: return 20'h00700;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 7; i++) begin m_prev[i] = 0; m_pend[i] = 0; end
      m_cs = 0; m_take = 0; m_vec = '0;
    end else begin
      lv[0] = sreset; lv[1] = mchk; lv[2] = smi; lv[3] = ext;
      lv[4] = thrm;   lv[5] = dec;  lv[6] = perf;
      for (int i = 0; i < 7; i++) arm[i] = 1;
      arm[1] = me; arm[5] = ee;
      trip = lv[1] && !m_prev[1] && !me;
      pick = -1; mv = '0;
      if (!m_cs && !trip) begin
        if (m_pend[0]) begin pick = 0; mv = 20'h00100; end
        else if (m_pend[1]) begin pick = 1; mv = 20'h00200; end
        else if (!m_take) begin
          for (int a = 0; a < 16; a++)
            for (int s = 0; s < 4; s++)
              if (mv == '0 && slot_ok(s) && f_age[4*s +: 4] == a) mv = slot_vec(s);
          if (mv == '0 && c_vld && bp_en && bp_a == c_wa && bp_te == ir) mv = 20'h01300;
          if (mv == '0 && c_vld && !c_isync && (se || (c_br && be))) mv = 20'h00D00;
          if (mv == '0 && ee)
            for (int j = 0; j < 5; j++)
              if (mv == '0 && m_pend[j+2]) begin pick = j + 2; mv = ord_vec[j]; end
        end
      end
      if (pick >= 0) m_pend[pick] = 0;
      for (int i = 0; i < 7; i++) begin
        if (lv[i] && !m_prev[i] && arm[i]) m_pend[i] = 1;
        m_prev[i] = lv[i];
      end
      if (trip) m_cs = 1;
      m_take = (mv != '0);
      m_vec  = mv;
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      check(tag_of(m_vec), "take", {31'd0, take_o}, {31'd0, m_take});
      check(tag_of(m_vec), "vector", {12'd0, vec_o}, {12'd0, m_vec});
      check("R4", "checkstop", {31'd0, checkstop_o}, {31'd0, m_cs});
      check("R12", "recov", {31'd0, recov_o}, {31'd0, ri & stq & nd});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_take(input string tag, input logic [19:0] v);
    #2;
    check(tag, "take strobe", {31'd0, take_o}, 32'd1);
    check(tag, "vector", {12'd0, vec_o}, {12'd0, v});
  endtask

  task automatic expect_idle(input string tag);
    #2;
    check(tag, "no take", {31'd0, take_o}, 32'd0);
  endtask

  task automatic set_slot(input int s, input logic [1:0] k, input logic [3:0] a);
    f_vld[s] = 1'b1;
    f_kind[2*s +: 2] = k;
    f_age[4*s +: 4] = a;
  endtask

  task automatic clr_all_sync();
    f_vld = '0; f_kind = '1; f_age = '0;
    c_vld = 0; c_br = 0; c_isync = 0; se = 0; be = 0;
  endtask

  initial begin
    rst_n = 0; sreset = 0; mchk = 0; me = 1;
    ext = 0; dec = 0; smi = 0; thrm = 0; perf = 0;
    ee = 0; fp = 0; ir = 0; ri = 0; stq = 0; nd = 0;
    c_wa = '0; bp_a = '0; bp_te = 0; bp_en = 0;
    clr_all_sync();
    tick(4);
    #2;
    check("R1", "take in reset", {31'd0, take_o}, 32'd0);
    check("R1", "vector in reset", {12'd0, vec_o}, 32'd0);
    check("R1", "checkstop in reset", {31'd0, checkstop_o}, 32'd0);
    rst_n = 1;
    tick();
    #2 check("R1", "take after reset", {31'd0, take_o}, 32'd0);
    tick();

    // R5: single program fault
    set_slot(2, 2'd0, 4'd5);
    tick(); expect_take("R5", 20'h00700);
    clr_all_sync(); tick(2);

    // R5: oldest wins, tie on lowest index, FPU gated by fp
    set_slot(0, 2'd2, 4'd7); set_slot(1, 2'd1, 4'd3); set_slot(3, 2'd0, 4'd3);
    tick(); expect_take("R5", 20'h00800);
    clr_all_sync(); tick(2);
    fp = 1;
    set_slot(0, 2'd2, 4'd7); set_slot(1, 2'd1, 4'd3); set_slot(3, 2'd0, 4'd3);
    tick(); expect_take("R5", 20'h00700);
    clr_all_sync(); fp = 0; tick(2);

    // R7: isync never traces; branch trace; single step
    c_vld = 1; c_isync = 1; se = 1;
    tick(); expect_idle("R7");
    c_isync = 0; se = 0; c_br = 1; be = 1;
    tick(); expect_take("R7", 20'h00D00);
    clr_all_sync(); tick(2);
    c_vld = 1; se = 1;
    tick(); expect_take("R7", 20'h00D00);
    clr_all_sync(); tick(2);

    // R6: breakpoint match, TE mismatch, and priorities
    c_wa = 30'h48C; bp_a = 30'h48C; bp_en = 1; bp_te = 1; ir = 1;
    c_vld = 1;
    tick(); expect_take("R6", 20'h01300);
    clr_all_sync(); tick(2);
    bp_te = 0; c_vld = 1;
    tick(); expect_idle("R6");
    clr_all_sync(); bp_te = 1; tick(2);
    c_vld = 1; se = 1;
    tick(); expect_take("R6", 20'h01300);
    clr_all_sync(); tick(2);
    c_vld = 1; set_slot(0, 2'd2, 4'd9);
    tick(); expect_take("R6", 20'h00C00);
    clr_all_sync(); bp_en = 0; tick(2);

    // R8: decrementer edge needs EE
    dec = 1; tick(); dec = 0; tick(3); expect_idle("R8");
    ee = 1; dec = 1; tick(); tick(); expect_take("R8", 20'h00900);
    dec = 0; tick(2);
    // R9: held while EE=0
    dec = 1; tick(); ee = 0; tick(3); expect_idle("R9");
    ee = 1; tick(); expect_take("R9", 20'h00900);
    dec = 0; tick(2);

    // R9: fixed maskable order
    smi = 1; ext = 1; thrm = 1; dec = 1; perf = 1;
    tick(2); expect_take("R9", 20'h01400);
    tick(2); expect_take("R9", 20'h00500);
    tick(2); expect_take("R9", 20'h01700);
    tick(2); expect_take("R9", 20'h00900);
    tick(2); expect_take("R9", 20'h00F00);
    smi = 0; ext = 0; thrm = 0; dec = 0; perf = 0; tick(2);

    // R6: sync outranks a pending maskable
    ee = 0; ext = 1; tick();
    set_slot(0, 2'd0, 4'd1); ee = 1;
    tick(); expect_take("R6", 20'h00700);
    clr_all_sync(); tick(2); expect_take("R9", 20'h00500);
    ext = 0; tick(2);

    // R11: edge arriving during the acknowledge cycle is kept
    smi = 1; tick(2); expect_take("R9", 20'h01400);
    ext = 1; tick(2); expect_take("R11", 20'h00500);
    smi = 0; ext = 0; tick(2);

    // R2/R3: non-maskable order and back-to-back takes
    ext = 1; sreset = 1; mchk = 1;
    tick(2); expect_take("R2", 20'h00100);
    tick(); expect_take("R3", 20'h00200);
    tick(); expect_idle("R10");
    tick(); expect_take("R9", 20'h00500);
    ext = 0; sreset = 0; mchk = 0; tick(2);

    // R12: recoverable state
    ri = 1; stq = 1; nd = 1; #2 check("R12", "recov all set", {31'd0, recov_o}, 32'd1);
    tick(); ri = 0; #2 check("R12", "recov RI low", {31'd0, recov_o}, 32'd0);
    tick(); ri = 1; stq = 0; #2 check("R12", "recov queue busy", {31'd0, recov_o}, 32'd0);
    tick(); stq = 1; tick();

    // R4: disabled machine check trips checkstop and silences takes
    me = 0; mchk = 1; smi = 1;
    tick(); #2 check("R4", "checkstop set", {31'd0, checkstop_o}, 32'd1);
    tick(); expect_idle("R4");
    sreset = 1; tick(3); expect_idle("R4");
    #2 check("R4", "checkstop held", {31'd0, checkstop_o}, 32'd1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule